// File: doc/BRIEF.md
# Six-Decade Decimal Up/Down Counter

This block keeps a six-digit decimal count in packed BCD and runs entirely from one system clock. An external count line is brought into the clock domain and edge-detected. Each detected rising edge moves the count one step up or down unless the inhibit line holds it back. All six decades step together, with look-ahead carry and borrow, and the range wraps between 000000 and 999999. Two flags accompany the value. A carry flag marks a wrap for the length of the count pulse that caused it. A zero flag shows that every decade is zero.

The count can also be preset one digit at a time. A load request is captured and held internally. The next rising edge on any bit of a one-hot digit-strobe bus then writes the 4-bit data word into the decade that bit selects, and the request line may already be released by then. While a load is pending, and for one clock after the write, both flags are held low. An asynchronous clear zeroes the decades at any time without waiting for the clock.

Top module: `bcd6_counter`

## Requirements
- R1: After synchronous reset, `count_bcd` is 000000, `carry_o` is 0 and `zero_o` is 1.
- R2: With `up_dn` high, each rising edge of `cnt_in` increases the count by one. `count_bcd` shows the new value after the third rising `clk` edge that follows the `cnt_in` rise.
- R3: With `up_dn` low, each rising edge of `cnt_in` decreases the count by one, with the same latency as R2.
- R4: Every 4-bit field of `count_bcd` stays within 0 to 9, and digit k sits in bits [4k+3:4k]. A step ripples across decades: 000999 counts up to 001000, and 001000 counts down to 000999.
- R5: Counting up from 999999 gives 000000, and counting down from 000000 gives 999999.
- R6: If `cnt_hold` is high when the rising edge of `cnt_in` is sampled, that pulse has no effect. This includes the case where `cnt_hold` is raised at the same moment as `cnt_in`.
- R7: `carry_o` rises together with a step that wraps the count in either direction. It falls on the third `clk` edge after `cnt_in` falls. A step that does not wrap leaves it low.
- R8: `zero_o` is high exactly when all decades are zero and no load is in progress.
- R9: A high level on `clr` zeroes all decades at once, with no clock edge needed.
- R10: After `load_req` is seen high on a clock edge, the next rising edge on bit k of `dig_strobe` writes `load_bcd` into digit k. A strobe edge with no request pending changes nothing.
- R11: A `load_bcd` value above 9 is written as 9.
- R12: From the clock after `load_req` is seen high until one clock after the digit is written, `carry_o` and `zero_o` are both low. After that they return to their normal meaning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Asynchronous clear of all decades, active high |
| cnt_in | input | 1 | Count pulse line, asynchronous |
| up_dn | input | 1 | 1 = count up, 0 = count down |
| cnt_hold | input | 1 | Count inhibit, active high |
| load_req | input | 1 | Digit-load request, captured internally |
| dig_strobe | input | NDIG | One-hot digit-select strobes; bit k selects digit k |
| load_bcd | input | 4 | BCD data for the digit being loaded |
| count_bcd | output | 4*NDIG | Packed BCD count, digit 0 in the low nibble |
| carry_o | output | 1 | Wrap flag, held for the wrapping count pulse |
| zero_o | output | 1 | All decades zero |

## Verification
A decade whose look-ahead enable is wrong shows up on `count_bcd` at the first step that crosses a 9/0 boundary. In the worst case that is a non-BCD nibble, or a wrong neighbour digit, three clocks after the count edge. A stuck or mistimed wrap register shows up as `carry_o` being wrong while the pulse is still high, or as `carry_o` failing to drop three clocks after the pulse ends. A load controller left in the wrong state keeps `zero_o` low on a zero count, or makes a strobe write when no request was made. Both are visible one or two clocks after the strobe edge.

// File: rtl/bcd6_pkg.sv
package bcd6_pkg;

    typedef logic [3:0] bcd_t;

    typedef struct packed {
        logic up;
        logic inh;
        logic rise;
        logic fall;
    } cnt_ev_t;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_ARMED = 2'd1,
        LD_TAIL  = 2'd2
    } ld_state_t;

    function automatic bcd_t bcd_sat(input logic [3:0] raw);
        return (raw > 4'd9) ? 4'd9 : raw;
    endfunction

    function automatic bcd_t bcd_step(input bcd_t d, input logic up);
        if (up) return (d >= 4'd9) ? 4'd0 : d + 4'd1;
        else    return (d == 4'd0) ? 4'd9 : d - 4'd1;
    endfunction

endpackage

// File: rtl/bcd6_cnt_front.sv
module bcd6_cnt_front
    import bcd6_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cnt_in,
    input  logic    up_in,
    input  logic    inh_in,
    output cnt_ev_t ev
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [2:0] stg [SYNC_STAGES];
    logic       prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
            prev_q <= 1'b0;
        end else begin
            stg[0] <= {inh_in, up_in, cnt_in};
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            prev_q <= stg[LAST][0];
        end
    end

    always_comb begin
        ev.rise = stg[LAST][0] & ~prev_q;
        ev.fall = ~stg[LAST][0] & prev_q;
        ev.up   = stg[LAST][1];
        ev.inh  = stg[LAST][2];
    end
endmodule

// File: rtl/bcd6_decade.sv
module bcd6_decade
    import bcd6_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step_en,
    input  logic up,
    input  logic wr_en,
    input  bcd_t wr_val,
    output bcd_t digit
);
    always_ff @(posedge clk or posedge clr) begin
        if (clr)          digit <= '0;
        else if (rst)     digit <= '0;
        else if (wr_en)   digit <= wr_val;
        else if (step_en) digit <= bcd_step(digit, up);
    end
endmodule

// File: rtl/bcd6_load_ctl.sv
module bcd6_load_ctl
    import bcd6_pkg::*;
#(
    parameter int NDIG = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_req,
    input  logic [NDIG-1:0] strobe,
    output logic [NDIG-1:0] wr_sel,
    output logic            busy
);
    ld_state_t       state_q;
    logic [NDIG-1:0] strobe_q;
    logic [NDIG-1:0] rise;
    logic            one_rise;
    logic            wr;

    always_comb begin
        rise     = strobe & ~strobe_q;
        one_rise = (rise != '0) && ((rise & (rise - 1'b1)) == '0);
        wr       = (state_q == LD_ARMED) && one_rise;
        wr_sel   = wr ? rise : '0;
        busy     = (state_q != LD_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LD_IDLE;
            strobe_q <= '0;
        end else begin
            strobe_q <= strobe;
            unique case (state_q)
                LD_IDLE:  if (load_req) state_q <= LD_ARMED;
                LD_ARMED: if (wr)       state_q <= LD_TAIL;
                LD_TAIL:  state_q <= load_req ? LD_ARMED : LD_IDLE;
                default:  state_q <= LD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bcd6_counter.sv
module bcd6_counter
    import bcd6_pkg::*;
#(
    parameter int NDIG        = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cnt_in,
    input  logic              up_dn,
    input  logic              cnt_hold,
    input  logic              load_req,
    input  logic [NDIG-1:0]   dig_strobe,
    input  logic [3:0]        load_bcd,
    output logic [4*NDIG-1:0] count_bcd,
    output logic              carry_o,
    output logic              zero_o
);
    localparam int VW = 4 * NDIG;

    cnt_ev_t         ev;
    logic [NDIG-1:0] wr_sel;
    logic            busy;
    logic            step;
    logic [NDIG-1:0] term;
    logic [NDIG-1:0] look;
    logic            carry_q;
    bcd_t            digit [NDIG];
    bcd_t            wr_val;

    bcd6_cnt_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
        .clk(clk), .rst(rst), .cnt_in(cnt_in),
        .up_in(up_dn), .inh_in(cnt_hold), .ev(ev)
    );

    bcd6_load_ctl #(.NDIG(NDIG)) load_i (
        .clk(clk), .rst(rst), .load_req(load_req),
        .strobe(dig_strobe), .wr_sel(wr_sel), .busy(busy)
    );

    assign wr_val = bcd_sat(load_bcd);
    // a write cycle takes the decade path; a coinciding count step is dropped
    assign step   = ev.rise & ~ev.inh & ~(|wr_sel);

    for (genvar i = 0; i < NDIG; i++) begin : g_dec
        assign term[i] = ev.up ? (digit[i] == 4'd9) : (digit[i] == 4'd0);
        if (i == 0) begin : g_lsd
            assign look[i] = 1'b1;
        end else begin : g_upper
            assign look[i] = &term[i-1:0];
        end
        bcd6_decade dec_i (
            .clk(clk), .rst(rst), .clr(clr),
            .step_en(step & look[i]), .up(ev.up),
            .wr_en(wr_sel[i]), .wr_val(wr_val), .digit(digit[i])
        );
        assign count_bcd[4*i +: 4] = digit[i];
    end

    always_ff @(posedge clk) begin
        if (rst)                   carry_q <= 1'b0;
        else if (step && (&term))  carry_q <= 1'b1;
        else if (ev.fall)          carry_q <= 1'b0;
    end

    assign carry_o = carry_q & ~busy;
    assign zero_o  = (count_bcd == {VW{1'b0}}) & ~busy;
endmodule

// File: rtl/bcd6_counter_chk.sv
module bcd6_counter_chk #(
    parameter int NDIG = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              load_req,
    input logic [4*NDIG-1:0] count_bcd,
    input logic              carry_o,
    input logic              zero_o,
    input logic              carry_q
);
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        a_r4_digit_decimal: assert property (@(posedge clk) disable iff (rst)
            count_bcd[4*i +: 4] <= 4'd9);
    end

    a_r7_carry_at_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(carry_q) |-> (count_bcd == '0 || count_bcd == {NDIG{4'h9}}));

    a_r8_zero_means_zero: assert property (@(posedge clk) disable iff (rst)
        zero_o |-> (count_bcd == '0));

    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr |-> (count_bcd == '0));

    a_r12_flags_quiet: assert property (@(posedge clk) disable iff (rst)
        load_req |=> (!carry_o && !zero_o));
endmodule

bind bcd6_counter bcd6_counter_chk #(.NDIG(NDIG)) chk_i (
    .clk(clk), .rst(rst), .clr(clr), .load_req(load_req),
    .count_bcd(count_bcd), .carry_o(carry_o), .zero_o(zero_o),
    .carry_q(carry_q)
);

// File: tb/bcd6_counter_tb.sv
`timescale 1ns/1ps
module bcd6_counter_tb_top;
    localparam int NDIG = 6;
    localparam int MOD  = 1000000;

    logic clk = 1'b0;
    logic rst = 1'b1, clr = 1'b0, cnt_in = 1'b0, up_dn = 1'b1, cnt_hold = 1'b0;
    logic load_req = 1'b0;
    logic [NDIG-1:0] dig_strobe = '0;
    logic [3:0] load_bcd = '0;
    logic [4*NDIG-1:0] count_bcd;
    logic carry_o, zero_o;

    int ntest = 0, nfail = 0, exp_n = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bcd6_counter #(.NDIG(NDIG)) dut_i (
        .clk(clk), .rst(rst), .clr(clr), .cnt_in(cnt_in), .up_dn(up_dn),
        .cnt_hold(cnt_hold), .load_req(load_req), .dig_strobe(dig_strobe),
        .load_bcd(load_bcd), .count_bcd(count_bcd), .carry_o(carry_o),
        .zero_o(zero_o)
    );

    function automatic logic [23:0] to_bcd(input int n);
        logic [23:0] r = '0;
        int v = n;
        for (int i = 0; i < NDIG; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    function automatic int put_digit(input int n, input int k, input int d);
        int p = 1;
        for (int i = 0; i < k; i++) p = p * 10;
        return n - ((n / p) % 10) * p + d * p;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        ntest++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic pulse(input logic up, input logic inh,
                         output logic cy_hi, output logic cy_lo);
        @(negedge clk);
        up_dn = up; cnt_hold = inh; cnt_in = 1'b1;
        repeat (4) @(negedge clk);
        cy_hi = carry_o;
        cnt_in = 1'b0;
        repeat (4) @(negedge clk);
        cy_lo = carry_o;
        cnt_hold = 1'b0;
    endtask

    task automatic count_step(input string tag, input logic up, input logic inh);
        logic hi, lo;
        bit wrap;
        wrap = !inh && (up ? exp_n == MOD - 1 : exp_n == 0);
        pulse(up, inh, hi, lo);
        if (!inh) exp_n = up ? (exp_n + 1) % MOD : (exp_n + MOD - 1) % MOD;
        chk({tag, " value"}, 32'(count_bcd), 32'(to_bcd(exp_n)));
        chk("R7 carry during pulse", 32'(hi), 32'(wrap));
        chk("R7 carry after pulse", 32'(lo), 32'd0);
        chk("R8 zero flag", 32'(zero_o), 32'(exp_n == 0));
    endtask

    task automatic load_digit(input int k, input logic [3:0] data);
        @(negedge clk);
        load_req = 1'b1;
        @(negedge clk);
        chk("R12 zero low while armed", 32'(zero_o), 32'd0);
        chk("R12 carry low while armed", 32'(carry_o), 32'd0);
        load_req = 1'b0;
        @(negedge clk);
        load_bcd = data;
        dig_strobe = NDIG'(1) << k;
        @(negedge clk);
        exp_n = put_digit(exp_n, k, (data > 9) ? 9 : int'(data));
        chk("R10/R11 loaded value", 32'(count_bcd), 32'(to_bcd(exp_n)));
        chk("R12 zero low one clock after write", 32'(zero_o), 32'd0);
        @(negedge clk);
        chk("R12 zero restored", 32'(zero_o), 32'(exp_n == 0));
        dig_strobe = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nfail++; ntest++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset value", 32'(count_bcd), 32'd0);
        chk("R1 reset carry", 32'(carry_o), 32'd0);
        chk("R1 reset zero", 32'(zero_o), 32'd1);

        count_step("R2 up", 1'b1, 1'b0);
        count_step("R2 up", 1'b1, 1'b0);
        count_step("R3 down", 1'b0, 1'b0);
        count_step("R6 inhibit coincident", 1'b1, 1'b1);

        load_digit(0, 4'd9); load_digit(1, 4'd9); load_digit(2, 4'd9);
        count_step("R4 ripple up", 1'b1, 1'b0);
        count_step("R4 ripple down", 1'b0, 1'b0);

        load_digit(3, 4'hC); load_digit(4, 4'hF); load_digit(5, 4'd9);
        count_step("R5 wrap up", 1'b1, 1'b0);
        count_step("R5 wrap down", 1'b0, 1'b0);
        count_step("R6 inhibit", 1'b0, 1'b1);

        @(negedge clk);
        dig_strobe = 6'b000100; load_bcd = 4'd5;
        repeat (2) @(negedge clk);
        chk("R10 strobe without request ignored", 32'(count_bcd), 32'(to_bcd(exp_n)));
        dig_strobe = '0;

        @(negedge clk);
        clr = 1'b1;
        #1;
        exp_n = 0;
        chk("R9 async clear", 32'(count_bcd), 32'd0);
        @(negedge clk);
        clr = 1'b0;
        load_digit(2, 4'd0);

        for (int i = 0; i < 150; i++) begin
            logic u, h;
            u = 1'($urandom_range(1, 0));
            h = ($urandom_range(9, 0) < 2);
            if ($urandom_range(19, 0) == 0)
                load_digit(int'($urandom_range(NDIG - 1, 0)), 4'($urandom_range(15, 0)));
            count_step(u ? "R2 random up" : "R3 random down", u, h);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end
endmodule